// File: doc/BRIEF.md
# Gated UART External FIFO Datapath

This block sits between a standard UART's receive and transmit holding registers and two external byte queues, one for each direction. While the extension is switched on, the host's accesses to the UART data port no longer reach the UART. Host writes fill the transmit queue, and host reads empty the receive queue.

Two transfer paths run on their own. One path moves received bytes from the UART into the receive queue. The other moves queued bytes from the transmit queue into the UART. Each path moves at most one byte per clock. Each path can be held off by its own bit of the modem-control byte. A single host write to a fixed offset empties both queues at once. Each queue reports empty, half-full and full. A swap mode exchanges the lower and upper halves of the 16-byte host window.

Serial framing, baud generation and interrupt logic belong to neighbouring blocks.

Top module: `uart_xfifo_path`

## Requirements
- R1: After a synchronous reset both queues are empty. rx_empty and tx_empty are 1, rx_half and tx_half are 0, rx_full_n is 1, tx_full is 0 and host_rdata is 0.
- R2: With xfifo_en=1, a host write to the data port (offset 8) pushes host_wdata into the transmit queue. A host read of the data port pops the receive queue, and the byte appears on host_rdata one cycle later. uart_port_wr and uart_port_rd stay 0. With xfifo_en=0 the same accesses raise uart_port_wr or uart_port_rd in the same cycle and leave both queues unchanged.
- R3: rx_take is 1 exactly when xfifo_en=1, rx_avail=1, the receive queue is not full, modem_ctrl bit 3 is 0 and no flush is being written. On that edge rx_byte is stored.
- R4: tx_give is 1 exactly when xfifo_en=1, tx_ready=1, the transmit queue is not empty, modem_ctrl bit 2 is 0 and no flush is being written. tx_byte then shows the oldest queued byte, which is removed on that edge.
- R5: A host write to offset 2 empties both queues on the next edge, whatever the state of xfifo_en. It takes priority over any push or pop in the same cycle.
- R6: The flags are registered and describe the fill level after the last edge. Empty means a level of 0, half means a level of at least DEPTH/2, and full means a level of DEPTH. The receive full flag rx_full_n is active low. All other flags are active high.
- R7: With swap_en=1 the host address is XORed with 8 before decoding. The data port then sits at offset 0 and the flush at offset 10, and offsets 8 and 2 select neither.
- R8: A host write to a full transmit queue is dropped. A host read of an empty receive queue returns 0. Neither access moves a pointer, so later bytes keep their order.
- R9: Both queues keep first-in first-out order across a full fill and drain of DEPTH bytes, at one byte per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xfifo_en | input | 1 | Extension on: data port redirected, transfer paths run |
| swap_en | input | 1 | Exchange the lower and upper 8-byte halves of the host window |
| modem_ctrl | input | 8 | Modem-control byte. Bit 3 holds the receive path, bit 2 holds the transmit path |
| host_addr | input | 4 | Host offset within the 16-byte window |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data from the receive queue |
| uart_port_wr | output | 1 | Data-port write belongs to the UART (extension off) |
| uart_port_rd | output | 1 | Data-port read belongs to the UART (extension off) |
| rx_avail | input | 1 | UART holds a received byte |
| rx_byte | input | 8 | UART received byte |
| rx_take | output | 1 | Byte taken from the UART this cycle |
| tx_ready | input | 1 | UART can accept a byte to send |
| tx_byte | output | 8 | Oldest transmit queue byte |
| tx_give | output | 1 | Byte handed to the UART this cycle |
| rx_empty | output | 1 | Receive queue empty |
| rx_half | output | 1 | Receive queue at least half full |
| rx_full_n | output | 1 | Receive queue full, active low |
| tx_empty | output | 1 | Transmit queue empty |
| tx_half | output | 1 | Transmit queue at least half full |
| tx_full | output | 1 | Transmit queue full |

## Verification
The bench fills each queue to exactly DEPTH and then tries one more byte. A queue whose full test is off by one would either overwrite its oldest byte or refuse the last one, and the drained sequence shows which. It reads an empty receive queue and then pushes a fresh byte. A design that moved the read pointer on an empty read would return stale data in place of that fresh byte. It writes a flush while a received byte is offered, and a design that let the push win would leave the receive queue non-empty. It then walks the address map with and without swap. A decoder that ignored the swap, or treated offset 8 as the data port in both modes, would push or pass through on the wrong offsets.

// File: rtl/uart_xfifo_pkg.sv
package uart_xfifo_pkg;
  // Bit positions inside the modem-control byte that hold each path
  localparam int RX_HOLD_BIT = 3;
  localparam int TX_HOLD_BIT = 2;

  // Decoded host access
  typedef struct packed {
    logic fifo_wr;
    logic fifo_rd;
    logic flush;
    logic uart_wr;
    logic uart_rd;
  } host_dec_t;
endpackage

// File: rtl/xfifo_host_dec.sv
module xfifo_host_dec
  import uart_xfifo_pkg::*;
#(
  parameter int AW        = 4,
  parameter int DATA_OFS  = 8,
  parameter int FLUSH_OFS = 2
) (
  input  logic [AW-1:0] host_addr,
  input  logic          swap_en,
  input  logic          xfifo_en,
  input  logic          host_wr,
  input  logic          host_rd,
  output host_dec_t     dec
);
  localparam logic [AW-1:0] HALF_FLIP = AW'(1) << (AW - 1);

  logic [AW-1:0] eff_addr;
  logic          data_hit;
  logic          flush_hit;

  // The swap mode exchanges the two halves of the window
  assign eff_addr  = host_addr ^ (swap_en ? HALF_FLIP : '0);
  assign data_hit  = (eff_addr == AW'(DATA_OFS));
  assign flush_hit = (eff_addr == AW'(FLUSH_OFS));

  always_comb begin
    dec.fifo_wr = host_wr && data_hit && xfifo_en;
    dec.fifo_rd = host_rd && data_hit && xfifo_en;
    dec.uart_wr = host_wr && data_hit && !xfifo_en;
    dec.uart_rd = host_rd && data_hit && !xfifo_en;
    dec.flush   = host_wr && flush_hit;
  end
endmodule

// File: rtl/xfifo_buf.sv
module xfifo_buf #(
  parameter int DW    = 8,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic          empty,
  output logic          half,
  output logic          full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;
  localparam logic [CW-1:0] LVL_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] LVL_HALF = CW'(DEPTH / 2);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] level, level_nx;
  logic          do_push, do_pop;

  // Guards live here too, so a caller's mistake cannot corrupt pointers
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  assign head = mem[rd_ptr];

  always_comb begin
    if (flush) level_nx = '0;
    else       level_nx = level + CW'(do_push) - CW'(do_pop);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + PW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + PW'(1);
    end
  end

  // Flags are registered from the next level
  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
      empty <= 1'b1;
      half  <= 1'b0;
      full  <= 1'b0;
    end else begin
      level <= level_nx;
      empty <= (level_nx == '0);
      half  <= (level_nx >= LVL_HALF);
      full  <= (level_nx == LVL_FULL);
    end
  end
endmodule

// File: rtl/xfifo_xfer.sv
module xfifo_xfer
  import uart_xfifo_pkg::*;
(
  input  logic       xfifo_en,
  input  logic [7:0] modem_ctrl,
  input  logic       flush,
  input  logic       rx_avail,
  input  logic       rx_q_full,
  input  logic       tx_ready,
  input  logic       tx_q_empty,
  output logic       rx_take,
  output logic       tx_give
);
  logic rx_hold, tx_hold;

  assign rx_hold = modem_ctrl[RX_HOLD_BIT];
  assign tx_hold = modem_ctrl[TX_HOLD_BIT];

  // A flush cycle moves nothing, so no byte is acknowledged and then lost
  assign rx_take = xfifo_en && !flush && !rx_hold && rx_avail && !rx_q_full;
  assign tx_give = xfifo_en && !flush && !tx_hold && tx_ready && !tx_q_empty;
endmodule

// File: rtl/uart_xfifo_path.sv
module uart_xfifo_path
  import uart_xfifo_pkg::*;
#(
  parameter int DW        = 8,
  parameter int DEPTH     = 16,
  parameter int AW        = 4,
  parameter int DATA_OFS  = 8,
  parameter int FLUSH_OFS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          xfifo_en,
  input  logic          swap_en,
  input  logic [7:0]    modem_ctrl,
  input  logic [AW-1:0] host_addr,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          uart_port_wr,
  output logic          uart_port_rd,
  input  logic          rx_avail,
  input  logic [DW-1:0] rx_byte,
  output logic          rx_take,
  input  logic          tx_ready,
  output logic [DW-1:0] tx_byte,
  output logic          tx_give,
  output logic          rx_empty,
  output logic          rx_half,
  output logic          rx_full_n,
  output logic          tx_empty,
  output logic          tx_half,
  output logic          tx_full
);
  host_dec_t     dec;
  logic          rx_full;
  logic [DW-1:0] rx_head;

  xfifo_host_dec #(
    .AW(AW), .DATA_OFS(DATA_OFS), .FLUSH_OFS(FLUSH_OFS)
  ) i_dec (
    .host_addr(host_addr), .swap_en(swap_en), .xfifo_en(xfifo_en),
    .host_wr(host_wr), .host_rd(host_rd), .dec(dec)
  );

  xfifo_xfer i_xfer (
    .xfifo_en(xfifo_en), .modem_ctrl(modem_ctrl), .flush(dec.flush),
    .rx_avail(rx_avail), .rx_q_full(rx_full),
    .tx_ready(tx_ready), .tx_q_empty(tx_empty),
    .rx_take(rx_take), .tx_give(tx_give)
  );

  xfifo_buf #(.DW(DW), .DEPTH(DEPTH)) i_rxq (
    .clk(clk), .rst(rst), .flush(dec.flush),
    .push(rx_take), .wdata(rx_byte), .pop(dec.fifo_rd),
    .head(rx_head), .empty(rx_empty), .half(rx_half), .full(rx_full)
  );

  xfifo_buf #(.DW(DW), .DEPTH(DEPTH)) i_txq (
    .clk(clk), .rst(rst), .flush(dec.flush),
    .push(dec.fifo_wr), .wdata(host_wdata), .pop(tx_give),
    .head(tx_byte), .empty(tx_empty), .half(tx_half), .full(tx_full)
  );

  assign rx_full_n    = ~rx_full;
  assign uart_port_wr = dec.uart_wr;
  assign uart_port_rd = dec.uart_rd;

  // Registered read port: an empty queue or a non-queue read gives zero
  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= (dec.fifo_rd && !rx_empty) ? rx_head : '0;
  end
endmodule

// File: rtl/uart_xfifo_path_chk.sv
module uart_xfifo_path_chk
  import uart_xfifo_pkg::*;
#(
  parameter int DW        = 8,
  parameter int AW        = 4,
  parameter int DATA_OFS  = 8,
  parameter int FLUSH_OFS = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          xfifo_en,
  input logic          swap_en,
  input logic [7:0]    modem_ctrl,
  input logic [AW-1:0] host_addr,
  input logic          host_wr,
  input logic [DW-1:0] host_rdata,
  input logic          uart_port_wr,
  input logic          uart_port_rd,
  input logic          rx_avail,
  input logic          rx_take,
  input logic          tx_ready,
  input logic          tx_give,
  input logic          rx_empty,
  input logic          rx_half,
  input logic          rx_full_n,
  input logic          tx_empty,
  input logic          tx_half,
  input logic          tx_full
);
  localparam logic [AW-1:0] FLIP = AW'(1) << (AW - 1);
  logic [AW-1:0] eff;
  logic          wr_flush, wr_data;

  assign eff      = host_addr ^ (swap_en ? FLIP : '0);
  assign wr_flush = host_wr && (eff == AW'(FLUSH_OFS));
  assign wr_data  = host_wr && (eff == AW'(DATA_OFS)) && xfifo_en;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (rx_empty && tx_empty && rx_full_n && !tx_full && !rx_half && !tx_half
             && host_rdata == '0));

  a_r2_no_passthru: assert property (@(posedge clk) disable iff (rst)
    xfifo_en |-> (!uart_port_wr && !uart_port_rd));

  a_r3_take_gated: assert property (@(posedge clk) disable iff (rst)
    rx_take |-> (xfifo_en && rx_avail && rx_full_n && !modem_ctrl[RX_HOLD_BIT]));

  a_r4_give_gated: assert property (@(posedge clk) disable iff (rst)
    tx_give |-> (xfifo_en && tx_ready && !tx_empty && !modem_ctrl[TX_HOLD_BIT]));

  a_r5_flush_empties: assert property (@(posedge clk) disable iff (rst)
    wr_flush |=> (rx_empty && tx_empty && rx_full_n && !tx_full));

  a_r6_full_is_half: assert property (@(posedge clk) disable iff (rst)
    (tx_full || !rx_full_n) |-> ((tx_full -> tx_half) && (!rx_full_n -> rx_half)));

  a_r6_empty_holds: assert property (@(posedge clk) disable iff (rst)
    (tx_empty && !wr_data) |=> tx_empty);

  a_r8_full_write_dropped: assert property (@(posedge clk) disable iff (rst)
    (tx_full && !tx_give && !wr_flush) |=> tx_full);
endmodule

bind uart_xfifo_path uart_xfifo_path_chk #(
  .DW(DW), .AW(AW), .DATA_OFS(DATA_OFS), .FLUSH_OFS(FLUSH_OFS)
) i_chk (.*);

// File: tb/test_uart_xfifo_path.sv
`timescale 1ns/1ps
module test_uart_xfifo_path;
  localparam int DEPTH = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       xfifo_en = 1'b0, swap_en = 1'b0;
  logic [7:0] modem_ctrl = 8'h00;
  logic [3:0] host_addr = 4'h0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       uart_port_wr, uart_port_rd;
  logic       rx_avail = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_take;
  logic       tx_ready = 1'b0;
  logic [7:0] tx_byte;
  logic       tx_give;
  logic       rx_empty, rx_half, rx_full_n, tx_empty, tx_half, tx_full;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_xfifo_path i_uart_xfifo_path (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  // Address map walk: {swap, en, addr[3:0], push, uart_wr, flush}
  localparam logic [8:0] VEC [9] = '{
    {1'b0, 1'b1, 4'd8,  1'b1, 1'b0, 1'b0},
    {1'b0, 1'b0, 4'd8,  1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 4'd2,  1'b0, 1'b0, 1'b1},
    {1'b1, 1'b1, 4'd0,  1'b1, 1'b0, 1'b0},
    {1'b1, 1'b1, 4'd8,  1'b0, 1'b0, 1'b0},
    {1'b1, 1'b1, 4'd10, 1'b0, 1'b0, 1'b1},
    {1'b0, 1'b1, 4'd0,  1'b0, 1'b0, 1'b0},
    {1'b1, 1'b0, 4'd0,  1'b0, 1'b1, 1'b0},
    {1'b0, 1'b1, 4'd9,  1'b0, 1'b0, 1'b0}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    int model;
    repeat (3) cyc();
    rst = 1'b0;
    // R1 reset state
    chk(rx_empty && tx_empty, "R1 empty flags", {rx_empty, tx_empty}, 3);
    chk(!rx_half && !tx_half, "R1 half flags", {rx_half, tx_half}, 0);
    chk(rx_full_n && !tx_full, "R1 full flags", {rx_full_n, tx_full}, 2);
    chk(host_rdata == 0, "R1 rdata", host_rdata, 0);

    // Table walk, R2 R5 R7: transmit queue level tracked by a model
    model = 0;
    foreach (VEC[i]) begin
      swap_en = VEC[i][8]; xfifo_en = VEC[i][7]; host_addr = VEC[i][6:3];
      host_wdata = 8'(8'h30 + i); host_wr = 1'b1;
      #1;
      chk(uart_port_wr == VEC[i][1], "R2/R7 passthrough strobe", uart_port_wr, VEC[i][1]);
      cyc();
      host_wr = 1'b0;
      if (VEC[i][0]) model = 0;
      else if (VEC[i][2]) model++;
      chk(tx_empty == (model == 0), "R7 decoded push/flush", tx_empty, model == 0);
    end
    swap_en = 1'b0; xfifo_en = 1'b1;
    host_addr = 4'd2; host_wr = 1'b1; cyc(); host_wr = 1'b0;

    // R6 R8 R9 transmit fill, overflow, hold, drain
    host_addr = 4'd8;
    for (int i = 0; i < DEPTH; i++) begin
      host_wdata = 8'(8'hA0 + i); host_wr = 1'b1; cyc();
      if (i == DEPTH/2 - 2) chk(!tx_half, "R6 tx below half", tx_half, 0);
      if (i == DEPTH/2 - 1) chk(tx_half, "R6 tx at half", tx_half, 1);
      if (i == DEPTH - 2)   chk(!tx_full, "R6 tx one short of full", tx_full, 0);
    end
    chk(tx_full, "R6 tx full", tx_full, 1);
    host_wdata = 8'hEE; cyc(); host_wr = 1'b0;   // R8 dropped
    chk(tx_full, "R8 tx still full", tx_full, 1);
    modem_ctrl = 8'h04; tx_ready = 1'b1; #1;
    chk(!tx_give, "R4 tx hold bit2", tx_give, 0);
    cyc();
    chk(tx_full, "R4 held queue unchanged", tx_full, 1);
    modem_ctrl = 8'h00;
    for (int i = 0; i < DEPTH; i++) begin
      #1;
      chk(tx_give, "R4 tx give", tx_give, 1);
      chk(tx_byte == 8'(8'hA0 + i), "R9 tx order", tx_byte, 8'hA0 + i);
      cyc();
    end
    chk(tx_empty && !tx_give, "R4 tx drained", {tx_empty, tx_give}, 2);
    tx_ready = 1'b0;

    // R3 receive hold, fill
    modem_ctrl = 8'h08; rx_avail = 1'b1; rx_byte = 8'h55; #1;
    chk(!rx_take, "R3 rx hold bit3", rx_take, 0);
    cyc();
    chk(rx_empty, "R3 held rx queue empty", rx_empty, 1);
    modem_ctrl = 8'h00;
    for (int i = 0; i < DEPTH; i++) begin
      rx_byte = 8'(8'h10 + i); #1;
      chk(rx_take, "R3 rx take", rx_take, 1);
      cyc();
    end
    chk(!rx_full_n, "R6 rx full active low", rx_full_n, 0);
    rx_byte = 8'hEE; #1;
    chk(!rx_take, "R3 no take when full", rx_take, 0);
    rx_avail = 1'b0;

    // R2 R9 host reads
    host_addr = 4'd8; host_rd = 1'b1;
    for (int i = 0; i < DEPTH; i++) begin
      cyc();
      chk(host_rdata == 8'(8'h10 + i), "R2/R9 rx read order", host_rdata, 8'h10 + i);
    end
    cyc();
    host_rd = 1'b0;
    chk(host_rdata == 0, "R8 empty read zero", host_rdata, 0);
    rx_avail = 1'b1; rx_byte = 8'h77; cyc(); rx_avail = 1'b0;
    host_rd = 1'b1; cyc(); host_rd = 1'b0;
    chk(host_rdata == 8'h77, "R8 pointers kept after empty read", host_rdata, 8'h77);

    // R5 flush priority over a concurrent receive push
    host_wdata = 8'h01; host_wr = 1'b1; cyc();
    rx_avail = 1'b1; rx_byte = 8'h99; cyc();
    chk(!tx_empty && !rx_empty, "R5 both queues loaded", {tx_empty, rx_empty}, 0);
    host_addr = 4'd2; #1;
    chk(!rx_take, "R5 no take in flush cycle", rx_take, 0);
    cyc(); host_wr = 1'b0; rx_avail = 1'b0;
    chk(rx_empty && tx_empty, "R5 flushed", {rx_empty, tx_empty}, 3);

    // R2 extension off: no transfers, read passes to UART
    xfifo_en = 1'b0; rx_avail = 1'b1; host_addr = 4'd8; host_rd = 1'b1; #1;
    chk(!rx_take, "R2 no take when disabled", rx_take, 0);
    chk(uart_port_rd, "R2 read passthrough", uart_port_rd, 1);
    cyc(); host_rd = 1'b0; rx_avail = 1'b0;
    chk(rx_empty && host_rdata == 0, "R2 disabled queue untouched", host_rdata, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule